// File: doc/BRIEF.md
# Prediction-Seeded Read-Retry Controller

This block handles host page reads for a flash controller whose cells lose charge as the stored data ages. For each accepted request it fetches the predicted read voltage code stored for the addressed block. It then issues the first flash read at that code, so the first attempt behaves like an ordinary read. It then waits for the pass or fail verdict from the ECC decoder.

When a decode fails, the same page is read again with the reference voltage code lowered by a fixed step. The code only ever moves downward, because charge leakage only lowers the voltage at which the fewest bits flip. Retrying stops at the first successful decode. It also stops when the retry budget is spent, or when a further step would take the code below zero. In either of those two cases an uncorrectable result is returned. Every response carries the number of retries used and the last voltage code tried.

Only one read is in flight at a time. The request side stays closed until the response has been taken.

Top module: `rretry_ctrl`

## Requirements
- R1: After reset, reqReady is 1 and lkpValid, rdValid and rspValid are all 0.
- R2: An accepted request raises lkpValid with lkpBlock equal to the requested block. After lkpDone, the first flash read carries the requested block and page and rdVcode equal to lkpVcode.
- R3: After a failed decode (eccValid=1, eccPass=0), the next read targets the same block and page with rdVcode lowered by STEP (default 4).
- R4: Within one request the voltage code never increases from one attempt to the next.
- R5: A passing decode (eccValid=1, eccPass=1) ends the request with rspOk=1. rspRetries equals the number of reads after the first, and rspVcode equals the code of the passing read.
- R6: At most MAX_RETRY (default 8) retries are made. A failure on the read after the last retry gives rspOk=0, rspRetries=MAX_RETRY and rspVcode equal to the last code tried.
- R7: If a read fails while its code is below STEP, no further read is issued. The response has rspOk=0 and rspVcode equal to that code, so the code never goes below 0.
- R8: Once a request is accepted, reqReady stays 0 until the response handshake (rspValid and rspReady both 1) completes.
- R9: While rspValid=1 and rspReady=0, rspValid, rspOk, rspRetries and rspVcode hold their values.
- R10: While rdValid=1 and rdReady=0, rdValid, rdBlock, rdPage and rdVcode hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host read request valid |
| reqReady | output | 1 | Controller idle and able to accept a request |
| reqBlock | input | BLK_W | Requested block address |
| reqPage | input | PAGE_W | Requested page address |
| lkpValid | output | 1 | Prediction lookup request |
| lkpBlock | output | BLK_W | Block whose prediction is wanted |
| lkpDone | input | 1 | Lookup result valid |
| lkpVcode | input | VCODE_W | Predicted voltage code for the block |
| rdValid | output | 1 | Flash read command valid |
| rdReady | input | 1 | Flash side accepts the command |
| rdBlock | output | BLK_W | Block address of the read |
| rdPage | output | PAGE_W | Page address of the read |
| rdVcode | output | VCODE_W | Reference voltage code for the read |
| eccValid | input | 1 | ECC verdict for the outstanding read is valid |
| eccPass | input | 1 | 1 when the read decoded correctly |
| rspValid | output | 1 | Response valid |
| rspReady | input | 1 | Host accepts the response |
| rspOk | output | 1 | 1 when the data was read correctly |
| rspRetries | output | CNT_W | Retries used for this request |
| rspVcode | output | VCODE_W | Last voltage code tried |

## Verification
The assertions check the following on every cycle:
- the step size between consecutive attempts;
- that the code does not rise without a fresh lookup;
- the retry counter bound;
- that the request side is closed once a request is accepted;
- that read commands and responses hold steady under backpressure;
- that the first read carries the looked-up code.

Only the bench scenarios can show the outcomes that depend on a whole sequence of ECC verdicts. These are:
- a first-try pass;
- a pass after several retries;
- a pass on exactly the last allowed retry;
- exhaustion of the retry budget;
- the stop at the bottom of the code range.

The bench also confirms the retry counts and final codes reported in each of those cases.

// File: rtl/rretry_pkg.sv
package rretry_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_ISSUE,
    ST_WAIT,
    ST_RESP
  } rrState_e;

  typedef struct packed {
    logic capReq;
    logic loadPred;
    logic stepDown;
  } rrStrobe_t;

endpackage

// File: rtl/rretry_dp.sv
module rretry_dp
  import rretry_pkg::*;
#(
  parameter int BLK_W     = 10,
  parameter int PAGE_W    = 8,
  parameter int VCODE_W   = 8,
  parameter int STEP      = 4,
  parameter int MAX_RETRY = 8,
  parameter int CNT_W     = $clog2(MAX_RETRY + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  rrStrobe_t          strb,
  input  logic [BLK_W-1:0]   reqBlock,
  input  logic [PAGE_W-1:0]  reqPage,
  input  logic [VCODE_W-1:0] predVcode,
  output logic [BLK_W-1:0]   blockQ,
  output logic [PAGE_W-1:0]  pageQ,
  output logic [VCODE_W-1:0] vcodeQ,
  output logic [CNT_W-1:0]   retriesQ,
  output logic               atLimit,
  output logic               atFloor
);

  localparam logic [VCODE_W-1:0] STEP_V = VCODE_W'(STEP);
  localparam logic [CNT_W-1:0]   LIMIT  = CNT_W'(MAX_RETRY);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blockQ <= '0;
      pageQ  <= '0;
    end else if (strb.capReq) begin
      blockQ <= reqBlock;
      pageQ  <= reqPage;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vcodeQ   <= '0;
      retriesQ <= '0;
    end else if (strb.loadPred) begin
      vcodeQ   <= predVcode;
      retriesQ <= '0;
    end else if (strb.stepDown) begin
      vcodeQ   <= vcodeQ - STEP_V;
      retriesQ <= retriesQ + 1'b1;
    end
  end

  always_comb begin
    atLimit = (retriesQ == LIMIT);
    atFloor = (vcodeQ < STEP_V);
  end

  // R3
  step_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepDown |=> (vcodeQ == $past(vcodeQ) - STEP_V) && (retriesQ == $past(retriesQ) + 1'b1));

  // R4
  no_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadPred |=> vcodeQ <= $past(vcodeQ));

  // R6
  retry_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    retriesQ <= LIMIT);

  // R7
  floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepDown |-> !atFloor);

endmodule

// File: rtl/rretry_ctl.sv
module rretry_ctl
  import rretry_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  output logic      lkpValid,
  input  logic      lkpDone,
  output logic      rdValid,
  input  logic      rdReady,
  input  logic      eccValid,
  input  logic      eccPass,
  output logic      rspValid,
  input  logic      rspReady,
  output logic      rspOk,
  input  logic      atLimit,
  input  logic      atFloor,
  output rrStrobe_t strb
);

  rrState_e stateQ, stateD;
  logic     okQ;
  logic     giveUp;

  always_comb begin
    giveUp = eccValid && !eccPass && (atLimit || atFloor);
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:   if (reqValid)  stateD = ST_LOOKUP;
      ST_LOOKUP: if (lkpDone)   stateD = ST_ISSUE;
      ST_ISSUE:  if (rdReady)   stateD = ST_WAIT;
      ST_WAIT: begin
        if (eccValid) begin
          if (eccPass || giveUp) stateD = ST_RESP;
          else                   stateD = ST_ISSUE;
        end
      end
      ST_RESP:   if (rspReady)  stateD = ST_IDLE;
      default:                  stateD = ST_IDLE;
    endcase
  end

  always_comb begin
    strb          = '0;
    strb.capReq   = (stateQ == ST_IDLE) && reqValid;
    strb.loadPred = (stateQ == ST_LOOKUP) && lkpDone;
    strb.stepDown = (stateQ == ST_WAIT) && eccValid && !eccPass && !giveUp;
    reqReady      = (stateQ == ST_IDLE);
    lkpValid      = (stateQ == ST_LOOKUP);
    rdValid       = (stateQ == ST_ISSUE);
    rspValid      = (stateQ == ST_RESP);
    rspOk         = okQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      okQ    <= 1'b0;
    end else begin
      stateQ <= stateD;
      if ((stateQ == ST_WAIT) && eccValid) okQ <= eccPass;
    end
  end

  // R8
  busy_closed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R8
  stay_closed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && !(rspValid && rspReady)) |=> !reqReady);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> rspValid && $stable(rspOk));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> rdValid);

endmodule

// File: rtl/rretry_ctrl.sv
module rretry_ctrl
  import rretry_pkg::*;
#(
  parameter int BLK_W     = 10,
  parameter int PAGE_W    = 8,
  parameter int VCODE_W   = 8,
  parameter int STEP      = 4,
  parameter int MAX_RETRY = 8,
  parameter int CNT_W     = $clog2(MAX_RETRY + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [BLK_W-1:0]   reqBlock,
  input  logic [PAGE_W-1:0]  reqPage,
  output logic               lkpValid,
  output logic [BLK_W-1:0]   lkpBlock,
  input  logic               lkpDone,
  input  logic [VCODE_W-1:0] lkpVcode,
  output logic               rdValid,
  input  logic               rdReady,
  output logic [BLK_W-1:0]   rdBlock,
  output logic [PAGE_W-1:0]  rdPage,
  output logic [VCODE_W-1:0] rdVcode,
  input  logic               eccValid,
  input  logic               eccPass,
  output logic               rspValid,
  input  logic               rspReady,
  output logic               rspOk,
  output logic [CNT_W-1:0]   rspRetries,
  output logic [VCODE_W-1:0] rspVcode
);

  rrStrobe_t          strb;
  logic [BLK_W-1:0]   blockQ;
  logic [PAGE_W-1:0]  pageQ;
  logic [VCODE_W-1:0] vcodeQ;
  logic [CNT_W-1:0]   retriesQ;
  logic               atLimit;
  logic               atFloor;

  rretry_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .lkpValid (lkpValid),
    .lkpDone  (lkpDone),
    .rdValid  (rdValid),
    .rdReady  (rdReady),
    .eccValid (eccValid),
    .eccPass  (eccPass),
    .rspValid (rspValid),
    .rspReady (rspReady),
    .rspOk    (rspOk),
    .atLimit  (atLimit),
    .atFloor  (atFloor),
    .strb     (strb)
  );

  rretry_dp #(
    .BLK_W     (BLK_W),
    .PAGE_W    (PAGE_W),
    .VCODE_W   (VCODE_W),
    .STEP      (STEP),
    .MAX_RETRY (MAX_RETRY),
    .CNT_W     (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqBlock  (reqBlock),
    .reqPage   (reqPage),
    .predVcode (lkpVcode),
    .blockQ    (blockQ),
    .pageQ     (pageQ),
    .vcodeQ    (vcodeQ),
    .retriesQ  (retriesQ),
    .atLimit   (atLimit),
    .atFloor   (atFloor)
  );

  always_comb begin
    lkpBlock   = blockQ;
    rdBlock    = blockQ;
    rdPage     = pageQ;
    rdVcode    = vcodeQ;
    rspRetries = retriesQ;
    rspVcode   = vcodeQ;
  end

  // R2
  first_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lkpValid && lkpDone) |=> rdValid && (rdVcode == $past(lkpVcode)));

  // R10
  rd_payload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> $stable(rdVcode) && $stable(rdBlock) && $stable(rdPage));

  // R9
  rsp_payload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> $stable(rspRetries) && $stable(rspVcode));

endmodule

// File: tb/sim_rretry_ctrl.sv
module sim_rretry_ctrl;

  localparam int BLK_W = 10, PAGE_W = 8, VCODE_W = 8, STEP = 4, MAX_RETRY = 8;
  localparam int CNT_W = $clog2(MAX_RETRY + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, lkpDone = 1'b0, rdReady = 1'b0;
  logic eccValid = 1'b0, eccPass = 1'b0, rspReady = 1'b0;
  logic [BLK_W-1:0]   reqBlock = '0;
  logic [PAGE_W-1:0]  reqPage = '0;
  logic [VCODE_W-1:0] lkpVcode = '0;
  logic reqReady, lkpValid, rdValid, rspValid, rspOk;
  logic [BLK_W-1:0]   lkpBlock, rdBlock;
  logic [PAGE_W-1:0]  rdPage;
  logic [VCODE_W-1:0] rdVcode, rspVcode;
  logic [CNT_W-1:0]   rspRetries;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rretry_ctrl u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // passAt < 0 means the decoder never passes; otherwise pass when code <= passAt
  task automatic doRead(input int blk, input int pg, input int pred, input int passAt,
                        input int lkpLat, input int expOk, input int expRetries,
                        input int expV);
    int attempt = 0;
    int lastV = pred;
    bool_loop: begin end
    @(negedge clk);
    chk(reqReady == 1'b1, "R8 ready when idle", int'(reqReady), 1);
    reqValid = 1'b1; reqBlock = BLK_W'(blk); reqPage = PAGE_W'(pg);
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqReady == 1'b0, "R8 ready low after accept", int'(reqReady), 0);
    chk(lkpValid == 1'b1, "R2 lookup raised", int'(lkpValid), 1);
    chk(int'(lkpBlock) == blk, "R2 lookup block", int'(lkpBlock), blk);
    for (int i = 0; i < lkpLat; i++) @(negedge clk);
    lkpDone = 1'b1; lkpVcode = VCODE_W'(pred);
    @(negedge clk);
    lkpDone = 1'b0;
    forever begin
      chk(rdValid == 1'b1, "R2/R3 read issued", int'(rdValid), 1);
      chk(int'(rdBlock) == blk && int'(rdPage) == pg, "R3 same page",
          int'(rdPage), pg);
      chk(int'(rdVcode) == pred - STEP * attempt, "R3 code step",
          int'(rdVcode), pred - STEP * attempt);
      chk(int'(rdVcode) <= lastV, "R4 no rise", int'(rdVcode), lastV);
      chk(reqReady == 1'b0, "R8 closed while busy", int'(reqReady), 0);
      lastV = int'(rdVcode);
      if (attempt == 0) begin
        @(negedge clk);
        chk(rdValid == 1'b1 && int'(rdVcode) == lastV, "R10 read held",
            int'(rdVcode), lastV);
      end
      rdReady = 1'b1;
      @(negedge clk);
      rdReady = 1'b0;
      @(negedge clk);
      eccValid = 1'b1;
      eccPass = (passAt >= 0) && (lastV <= passAt);
      @(negedge clk);
      eccValid = 1'b0; eccPass = 1'b0;
      if (rspValid) break;
      attempt++;
      if (attempt > MAX_RETRY + 1) break;
    end
    chk(rspValid == 1'b1, "R5/R6/R7 response raised", int'(rspValid), 1);
    @(negedge clk);
    chk(rspValid == 1'b1 && int'(rspVcode) == lastV, "R9 response held",
        int'(rspVcode), lastV);
    chk(reqReady == 1'b0, "R8 closed during response", int'(reqReady), 0);
    chk(int'(rspOk) == expOk, "R5/R6/R7 ok flag", int'(rspOk), expOk);
    chk(int'(rspRetries) == expRetries, "R5/R6/R7 retries", int'(rspRetries), expRetries);
    chk(int'(rspVcode) == expV, "R5/R6/R7 final code", int'(rspVcode), expV);
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    chk(rspValid == 1'b0 && reqReady == 1'b1, "R8 reopened", int'(reqReady), 1);
  endtask

  task automatic testReset();
    chk(reqReady == 1'b1, "R1 reqReady", int'(reqReady), 1);
    chk(!lkpValid && !rdValid && !rspValid, "R1 idle outputs",
        int'({lkpValid, rdValid, rspValid}), 0);
  endtask

  task automatic testFirstPass();    // R5
    doRead(17, 3, 100, 200, 0, 1, 0, 100);
  endtask

  task automatic testFewRetries();   // R3 R4 R5
    doRead(513, 200, 100, 88, 2, 1, 3, 88);
  endtask

  task automatic testLastRetryPass(); // R6 boundary: pass on retry 8
    doRead(5, 9, 50, 18, 1, 1, 8, 18);
  endtask

  task automatic testExhausted();    // R6
    doRead(1023, 255, 200, -1, 0, 0, 8, 168);
  endtask

  task automatic testFloor();        // R7
    doRead(40, 41, 10, -1, 3, 0, 2, 2);
  endtask

  task automatic testFloorAtStart(); // R7 code below step on first read
    doRead(2, 2, 3, -1, 0, 0, 0, 3);
  endtask

  task automatic testZeroPred();     // R5 with code 0
    doRead(0, 0, 0, 0, 0, 1, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFirstPass();
    testFewRetries();
    testLastRetryPass();
    testExhausted();
    testFloor();
    testFloorAtStart();
    testZeroPred();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule